// File: doc/BRIEF.md
# Overlay RAM Bank-Switch Controller

This block sits on a CPU bus next to an expansion RAM that can stand in for ROM in the top of the address space. It watches every bus cycle. When a cycle falls inside a 16-address soft-switch window, the block decodes the low address bits into a small set of mode settings. The RAM arrays, the ROM and the CPU timing sit outside this block. Its three registered outputs steer them:
- which of two 4 KB RAM banks fills the shared sub-window;
- whether reads are served from RAM or from ROM;
- whether writes land in RAM.

Writes to RAM are protected. Writing is only unlocked after two read cycles in a row that hit a write-capable switch. A read-modify-write instruction issues two reads and then a write to the same switch, so that instruction unlocks writing by itself. A single stray read does not.

The block registers all state on the rising clock edge. An output changes at the edge that samples the qualifying bus cycle.

Top module: `ovl_bank_ctrl`

## Requirements
- R1: After reset, `bank_one` = 0 (bank 2 selected), `rd_from_ram` = 0 (reads from ROM) and `ram_wr_en` = 0, with the write-unlock arming cleared.
- R2: A valid read of the window sets `bank_one` to address bit 3. A 0 selects bank 2 (for example offset 0x3) and a 1 selects bank 1 (for example offset 0xB).
- R3: A valid read of the window sets `rd_from_ram` from address bits 1:0. The codes 00 and 11 give 1 (RAM). The codes 01 and 10 give 0 (ROM).
- R4: Address bit 2 is not decoded. Offsets 0x4–0x7 and 0xC–0xF act exactly like 0x0–0x3 and 0x8–0xB.
- R5: A single valid read of an odd offset (address bit 0 = 1), with write access off, does not set `ram_wr_en`.
- R6: Two valid reads in a row of odd offsets set `ram_wr_en` at the second read. The two offsets may be the same or different.
- R7: A valid read of an even offset clears `ram_wr_en` and clears the arming, so a following single odd read leaves writes disabled.
- R8: A valid write cycle to the window leaves `bank_one`, `rd_from_ram` and `ram_wr_en` unchanged.
- R9: A valid write cycle to the window clears the arming. The sequence odd read, write, odd read leaves `ram_wr_en` = 0.
- R10: While `ram_wr_en` = 1, any odd-offset read keeps it at 1, even when that read changes the bank or the read source.
- R11: Cycles with `bus_valid` = 0, and cycles whose address lies outside the window, change no output and leave the arming as it was.
- R12: A read-modify-write pattern (two reads, then a write, all to the same odd offset) leaves `ram_wr_en` = 1 after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Marks a real bus cycle in this clock |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | ADDR_W (16) | Bus address; the window starts at parameter SW_BASE (default 0xC080) |
| bank_one | output | 1 | 1 = bank 1 mapped, 0 = bank 2 mapped |
| rd_from_ram | output | 1 | 1 = reads served from RAM, 0 = from ROM |
| ram_wr_en | output | 1 | 1 = writes reach RAM |

## Verification
A wrong bank or read-source register shows up on `bank_one` or `rd_from_ram` one clock after the read that should have set it. The arming flag has no port, so an error in it stays hidden until the next odd read. At that point `ram_wr_en` either rises one read too early or fails to rise. For that reason the directed sequences place an even read, a window write or an outside access between odd reads, and then check `ram_wr_en` right after the next odd read.

// File: rtl/ovl_bank_pkg.sv
package ovl_bank_pkg;

    // Write-unlock progress
    typedef enum logic [1:0] {
        WE_OFF   = 2'd0,   // writes blocked, nothing armed
        WE_ARMED = 2'd1,   // one odd read seen
        WE_ON    = 2'd2    // writes reach RAM
    } we_state_e;

    // Decoded meaning of one bus cycle
    typedef struct packed {
        logic rd_hit;     // valid read inside window
        logic wr_hit;     // valid write inside window
        logic odd;        // write-capable switch
        logic bank_one;   // bank requested by address bit 3
        logic src_ram;    // read source requested by bits 1:0
    } sw_cmd_t;

endpackage

// File: rtl/ovl_bank_decode.sv
module ovl_bank_decode
    import ovl_bank_pkg::*;
#(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080
) (
    input  logic              valid,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output sw_cmd_t           cmd
);
    localparam int PAGE_LSB = 4;

    logic in_window;
    logic unused_bit2;

    assign in_window   = valid && (addr[ADDR_W-1:PAGE_LSB] == SW_BASE[ADDR_W-1:PAGE_LSB]);
    assign unused_bit2 = addr[2];

    always_comb begin
        cmd.rd_hit   = in_window && rd;
        cmd.wr_hit   = in_window && !rd;
        cmd.odd      = addr[0];
        cmd.bank_one = addr[3];
        cmd.src_ram  = ~(addr[1] ^ addr[0]);
    end
endmodule

// File: rtl/ovl_bank_mode.sv
module ovl_bank_mode
    import ovl_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sw_cmd_t cmd,
    output logic    bank_one,
    output logic    src_ram
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_one <= 1'b0;
            src_ram  <= 1'b0;
        end else if (cmd.rd_hit) begin
            bank_one <= cmd.bank_one;
            src_ram  <= cmd.src_ram;
        end
    end
endmodule

// File: rtl/ovl_bank_wr_fsm.sv
module ovl_bank_wr_fsm
    import ovl_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sw_cmd_t cmd,
    output logic    wr_en
);
    we_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WE_OFF;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WE_OFF: begin
                if (cmd.rd_hit && cmd.odd) state_d = WE_ARMED;
            end
            WE_ARMED: begin
                if (cmd.rd_hit)      state_d = cmd.odd ? WE_ON : WE_OFF;
                else if (cmd.wr_hit) state_d = WE_OFF;
            end
            WE_ON: begin
                if (cmd.rd_hit && !cmd.odd) state_d = WE_OFF;
            end
            default: state_d = WE_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        wr_en = (state_q == WE_ON);
    end
endmodule

// File: rtl/ovl_bank_ctrl.sv
module ovl_bank_ctrl
    import ovl_bank_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bank_one,
    output logic              rd_from_ram,
    output logic              ram_wr_en
);
    sw_cmd_t cmd;

    ovl_bank_decode #(.ADDR_W(ADDR_W), .SW_BASE(SW_BASE)) u_dec (
        .valid (bus_valid),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .cmd   (cmd)
    );

    ovl_bank_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .bank_one (bank_one),
        .src_ram  (rd_from_ram)
    );

    ovl_bank_wr_fsm u_wfsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .wr_en (ram_wr_en)
    );
endmodule

// File: rtl/ovl_bank_ctrl_chk.sv
module ovl_bank_ctrl_chk #(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bank_one,
    input logic              rd_from_ram,
    input logic              ram_wr_en
);
    logic hit;
    assign hit = bus_valid && (bus_addr[ADDR_W-1:4] == SW_BASE[ADDR_W-1:4]);

    AST_RD_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        hit && bus_rd |=> bank_one == $past(bus_addr[3]));                              // R2
    AST_RD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        hit && bus_rd |=> rd_from_ram == ($past(bus_addr[1]) == $past(bus_addr[0])));  // R3
    AST_EVEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hit && bus_rd && !bus_addr[0] |=> !ram_wr_en);                                  // R7
    AST_WE_RISE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_wr_en) |-> $past(hit && bus_rd && bus_addr[0]));                     // R6
    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !bus_rd |=> $stable(bank_one) && $stable(rd_from_ram) && $stable(ram_wr_en)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(bank_one) && $stable(rd_from_ram) && $stable(ram_wr_en));      // R11
    AST_ON_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en && hit && bus_rd && bus_addr[0] |=> ram_wr_en);                       // R10
endmodule

bind ovl_bank_ctrl ovl_bank_ctrl_chk #(.ADDR_W(ADDR_W), .SW_BASE(SW_BASE)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bank_one    (bank_one),
    .rd_from_ram (rd_from_ram),
    .ram_wr_en   (ram_wr_en)
);

// File: tb/ovl_bank_ctrl_tb.sv
`timescale 1ns/1ps
module ovl_bank_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_rd = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic        bank_one, rd_from_ram, ram_wr_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state: arm 0 = off, 1 = armed, 2 = on
    logic m_bank, m_ram;
    int   m_arm;

    always #10 clk = ~clk;

    ovl_bank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bank_one(bank_one), .rd_from_ram(rd_from_ram),
        .ram_wr_en(ram_wr_en)
    );

    function automatic bit f_hit(input logic v, input logic [15:0] a);
        return v && (a[15:4] == 12'hC08);
    endfunction

    function automatic logic f_src(input logic [15:0] a);
        return (a[1:0] == 2'b00) || (a[1:0] == 2'b11);
    endfunction

    task automatic model_step(input logic v, input logic rd, input logic [15:0] a);
        if (f_hit(v, a)) begin
            if (rd) begin
                m_bank = a[3];
                m_ram  = f_src(a);
                if (a[0]) m_arm = (m_arm == 0) ? 1 : 2;
                else      m_arm = 0;
            end else if (m_arm == 1) begin
                m_arm = 0;
            end
        end
    endtask

    task automatic bus(input logic v, input logic rd, input logic [15:0] a);
        @(negedge clk);
        bus_valid = v; bus_rd = rd; bus_addr = a;
        @(posedge clk);
        #1;
        model_step(v, rd, a);
        bus_valid = 1'b0;
    endtask

    task automatic check(input string tag, input logic eb, input logic er, input logic ew);
        checks++;
        if (bank_one !== eb || rd_from_ram !== er || ram_wr_en !== ew) begin
            failures++;
            $display("FAIL %s: got bank=%b ram=%b we=%b expected bank=%b ram=%b we=%b",
                     tag, bank_one, rd_from_ram, ram_wr_en, eb, er, ew);
        end
    endtask

    task automatic check_model(input string tag);
        check(tag, m_bank, m_ram, m_arm == 2);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_bank = 0; m_ram = 0; m_arm = 0;
        repeat (3) @(posedge clk);
        #1 check("R1 reset", 0, 0, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) check("R1 after release", 0, 0, 0);

        bus(1, 1, 16'hC083); check("R5 single odd", 0, 1, 0);
        bus(1, 1, 16'hC083); check("R6 double 0x3", 0, 1, 1);
        bus(1, 1, 16'hC08B); check("R2 R10 bank switch keeps we", 1, 1, 1);
        bus(1, 1, 16'hC081); check("R10 source switch keeps we", 0, 0, 1);
        bus(1, 1, 16'hC080); check("R7 even clears", 0, 1, 0);
        bus(1, 1, 16'hC081); check("R5 armed once", 0, 0, 0);
        bus(1, 1, 16'hC088); check("R7 even after arm", 1, 1, 0);
        bus(1, 1, 16'hC089); check("R7 arming was cleared", 1, 0, 0);
        bus(1, 1, 16'hC089); check("R6 double 0x9", 1, 0, 1);
        bus(1, 0, 16'hC080); check("R8 write no change", 1, 0, 1);
        bus(1, 1, 16'hC082); check("R3 code 10 rom", 0, 0, 0);
        bus(1, 1, 16'hC081); bus(1, 0, 16'hC081); bus(1, 1, 16'hC081);
        check("R9 write breaks pair", 0, 0, 0);
        bus(1, 1, 16'hC080);
        bus(1, 1, 16'hC08B); bus(1, 1, 16'hC08B); bus(1, 0, 16'hC08B);
        check("R12 rmw enables", 1, 1, 1);
        bus(1, 1, 16'hC086); check("R4 mirror of 0x2", 0, 0, 0);
        bus(1, 1, 16'hC08F); bus(1, 1, 16'hC08D); check("R4 mirrors arm", 1, 0, 1);
        bus(0, 1, 16'hC080); check("R11 invalid cycle", 1, 0, 1);
        bus(1, 1, 16'hC090); check("R11 outside window", 1, 0, 1);
        bus(1, 1, 16'h4080); check("R11 other page", 1, 0, 1);
        bus(1, 1, 16'hC080);
        bus(1, 1, 16'hC083); bus(1, 1, 16'hD083); bus(1, 1, 16'hC08B);
        check("R11 outside keeps arming", 1, 1, 1);

        void'($urandom(32'd1234));
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] a;
            logic v, rd;
            a  = ($urandom % 4 != 0) ? (16'hC080 | 16'($urandom % 16)) : 16'($urandom);
            v  = ($urandom % 10) != 0;
            rd = ($urandom % 4) != 0;
            bus(v, rd, a);
            check_model("R2/R3/R6/R8/R9/R11 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule